// File: doc/BRIEF.md
# Calibration Step Sequencer for a Multi-Channel Delta-Sigma Decimator

This block runs the calibration steps of an eight-channel delta-sigma decimator. A two-bit command picks a step: input offset, noise or system offset. The block counts filter cycles, one for each strobe that marks an output conversion word. While a step runs, it raises a single calibrate enable that all eight channel modulators share. Until the step's fixed cycle count has elapsed, it ignores any further commands.

When a step finishes, the block captures the result word that an external datapath presents on its input ports. It stores that word, with an odd parity bit added, in one of four 24-bit calibration words: noise, offset high, offset low and gain. Every calibration word keeps its data in bits 23:1 and its parity in bit 0.

The command and result inputs are plain level signals: the results are sampled on the final filter strobe, and the step lengths already pace the exchange. For that reason the block has no valid/ready channel. It has no back-pressure, and the datapath needs no handshake to hold its result.

Top module: `cal_sequencer`

## Requirements
- R1: After reset, `busy`, `done` and `mod_cal_en` are 0, the noise word and both offset words are 0x000000, and the gain word is 0x199998.
- R2: Command code 1 (input offset) keeps `busy` high for exactly 23 filter strobes. When it ends, no calibration word changes.
- R3: While `busy` is high, changes on `cmd_code` have no effect, and `busy` stays high on every cycle without a strobe until the step's count is reached. A command is sampled only on a cycle with `busy` low, and code 0 starts nothing.
- R4: Command code 2 (noise) lasts exactly 409 strobes. On the last strobe, `noise_data` is stored in bits 23:1 of the noise word.
- R5: Starting a noise step sets both offset words to 0x000000 on the starting edge, and leaves the gain word unchanged.
- R6: Command code 3 (system offset) lasts exactly 1028 strobes. On the last strobe, the signed 43-bit `offset_data` is split into two words. The high word takes bit 42 repeated three times, then bits 41:22, in its bits 23:1. The low word takes bits 21:0 followed by a single 0 in its bits 23:1.
- R7: Bit 0 of every word written by R4 or R6 is an odd parity bit: the word has an odd number of ones.
- R8: `done` is high for exactly one cycle, the one right after the edge that ends a step. In that cycle `busy` is already low and the new words are visible.
- R9: All eight bits of `mod_cal_en` equal `busy` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_code | input | 2 | Step command: 0 none, 1 input offset, 2 noise, 3 system offset |
| filt_strobe | input | 1 | One-cycle pulse for each output conversion word |
| noise_data | input | 23 | Noise calibration result from the datapath |
| offset_data | input | 43 | Signed system offset result from the datapath |
| busy | output | 1 | High while a step is running |
| done | output | 1 | One-cycle pulse when a step ends |
| mod_cal_en | output | 8 | Shared calibrate enable to the modulators |
| noise_word | output | 24 | Noise calibration word, parity in bit 0 |
| offset_msw | output | 24 | Offset high word, parity in bit 0 |
| offset_lsw | output | 24 | Offset low word, parity in bit 0 |
| gain_word | output | 24 | Gain word, parity in bit 0 |

## Verification
The assertions take for granted that `cmd_code` is a valid code from the moment it is sampled. They also assume the result inputs are settled on the strobe that ends a step, since the checks of the written words look only at the words and not at the inputs. The bench changes commands and data only on falling clock edges. It returns `cmd_code` to 0 before the final strobe of each step, so that a step ending never coincides with a fresh command the bench did not intend. It also spaces strobes apart and inserts idle gaps, so that counting cannot depend on back-to-back pulses.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE   = 2'd0,
    CMD_INOFF  = 2'd1,
    CMD_NOISE  = 2'd2,
    CMD_SYSOFF = 2'd3
  } cal_cmd_e;
endpackage

// File: rtl/cal_odd_word.sv
module cal_odd_word #(
  parameter int DATA_W = 23
) (
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W:0]   word
);
  // append a bit so the total count of ones is odd
  assign word = {data, ~(^data)};
endmodule

// File: rtl/cal_step_timer.sv
module cal_step_timer
  import cal_seq_pkg::*;
#(
  parameter int IOFF_CYCLES  = 23,
  parameter int NOISE_CYCLES = 409,
  parameter int SOFF_CYCLES  = 1028
) (
  input  logic     clk,
  input  logic     rst_n,
  input  cal_cmd_e cmd,
  input  logic     strobe,
  output logic     busy,
  output cal_cmd_e mode,
  output logic     last
);
  localparam int MAX_A  = (IOFF_CYCLES > NOISE_CYCLES) ? IOFF_CYCLES : NOISE_CYCLES;
  localparam int MAX_C  = (MAX_A > SOFF_CYCLES) ? MAX_A : SOFF_CYCLES;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] end_cnt;

  always_comb begin
    case (mode)
      CMD_INOFF:  end_cnt = CNT_W'(IOFF_CYCLES - 1);
      CMD_NOISE:  end_cnt = CNT_W'(NOISE_CYCLES - 1);
      CMD_SYSOFF: end_cnt = CNT_W'(SOFF_CYCLES - 1);
      default:    end_cnt = '0;
    endcase
  end

  assign last = busy && strobe && (cnt_q == end_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      mode  <= CMD_IDLE;
      cnt_q <= '0;
    end else if (!busy) begin
      if (cmd != CMD_IDLE) begin
        busy  <= 1'b1;
        mode  <= cmd;
        cnt_q <= '0;
      end
    end else if (strobe) begin
      cnt_q <= cnt_q + 1'b1;
      if (last) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/cal_reg_bank.sv
module cal_reg_bank #(
  parameter int          WORD_W     = 24,
  parameter int          OFFSET_W   = 43,
  parameter int          LSW_BITS   = 22,
  parameter logic [23:0] GAIN_RESET = 24'h199998
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_offset,
  input  logic                wr_noise,
  input  logic                wr_offset,
  input  logic [WORD_W-2:0]   noise_data,
  input  logic [OFFSET_W-1:0] offset_data,
  output logic [WORD_W-1:0]   noise_word,
  output logic [WORD_W-1:0]   offset_msw,
  output logic [WORD_W-1:0]   offset_lsw,
  output logic [WORD_W-1:0]   gain_word
);
  localparam int DATA_W   = WORD_W - 1;
  localparam int MSW_BITS = OFFSET_W - 1 - LSW_BITS;
  localparam int SIGN_EXT = DATA_W - MSW_BITS;
  localparam int LSW_PAD  = DATA_W - LSW_BITS;

  logic [DATA_W-1:0] msw_data, lsw_data;
  logic [WORD_W-1:0] noise_nx, msw_nx, lsw_nx;

  assign msw_data = {{SIGN_EXT{offset_data[OFFSET_W-1]}},
                     offset_data[OFFSET_W-2:LSW_BITS]};
  assign lsw_data = {offset_data[LSW_BITS-1:0], {LSW_PAD{1'b0}}};

  cal_odd_word #(.DATA_W(DATA_W)) u_noise_par (.data(noise_data), .word(noise_nx));
  cal_odd_word #(.DATA_W(DATA_W)) u_msw_par   (.data(msw_data),   .word(msw_nx));
  cal_odd_word #(.DATA_W(DATA_W)) u_lsw_par   (.data(lsw_data),   .word(lsw_nx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      noise_word <= '0;
      offset_msw <= '0;
      offset_lsw <= '0;
      gain_word  <= WORD_W'(GAIN_RESET);
    end else begin
      if (wr_noise) noise_word <= noise_nx;
      if (clr_offset) begin
        offset_msw <= '0;
        offset_lsw <= '0;
      end else if (wr_offset) begin
        offset_msw <= msw_nx;
        offset_lsw <= lsw_nx;
      end
      gain_word <= gain_word;
    end
  end
endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer
  import cal_seq_pkg::*;
#(
  parameter int          WORD_W       = 24,
  parameter int          OFFSET_W     = 43,
  parameter int          NUM_MODS     = 8,
  parameter int          IOFF_CYCLES  = 23,
  parameter int          NOISE_CYCLES = 409,
  parameter int          SOFF_CYCLES  = 1028,
  parameter logic [23:0] GAIN_RESET   = 24'h199998
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cmd_code,
  input  logic                filt_strobe,
  input  logic [WORD_W-2:0]   noise_data,
  input  logic [OFFSET_W-1:0] offset_data,
  output logic                busy,
  output logic                done,
  output logic [NUM_MODS-1:0] mod_cal_en,
  output logic [WORD_W-1:0]   noise_word,
  output logic [WORD_W-1:0]   offset_msw,
  output logic [WORD_W-1:0]   offset_lsw,
  output logic [WORD_W-1:0]   gain_word
);
  localparam int LSW_BITS = 22;

  cal_cmd_e cmd_e, mode_q;
  logic     step_last, done_q;

  assign cmd_e = cal_cmd_e'(cmd_code);

  cal_step_timer #(
    .IOFF_CYCLES (IOFF_CYCLES),
    .NOISE_CYCLES(NOISE_CYCLES),
    .SOFF_CYCLES (SOFF_CYCLES)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd   (cmd_e),
    .strobe(filt_strobe),
    .busy  (busy),
    .mode  (mode_q),
    .last  (step_last)
  );

  cal_reg_bank #(
    .WORD_W    (WORD_W),
    .OFFSET_W  (OFFSET_W),
    .LSW_BITS  (LSW_BITS),
    .GAIN_RESET(GAIN_RESET)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_offset (!busy && (cmd_e == CMD_NOISE)),
    .wr_noise   (step_last && (mode_q == CMD_NOISE)),
    .wr_offset  (step_last && (mode_q == CMD_SYSOFF)),
    .noise_data (noise_data),
    .offset_data(offset_data),
    .noise_word (noise_word),
    .offset_msw (offset_msw),
    .offset_lsw (offset_lsw),
    .gain_word  (gain_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= step_last;
  end

  assign done = done_q;

  generate
    for (genvar m = 0; m < NUM_MODS; m++) begin : g_mod_en
      assign mod_cal_en[m] = busy;
    end
  endgenerate
endmodule

// File: rtl/cal_sequencer_chk.sv
module cal_sequencer_chk #(
  parameter int WORD_W   = 24,
  parameter int NUM_MODS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          cmd_code,
  input logic                filt_strobe,
  input logic                busy,
  input logic                done,
  input logic [1:0]          mode,
  input logic [NUM_MODS-1:0] mod_cal_en,
  input logic [WORD_W-1:0]   noise_word,
  input logic [WORD_W-1:0]   offset_msw,
  input logic [WORD_W-1:0]   offset_lsw,
  input logic [WORD_W-1:0]   gain_word
);
  a_r3_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !filt_strobe |=> busy);

  a_r5_offset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && cmd_code == 2'd2 |=> offset_msw == '0 && offset_lsw == '0);

  a_r5_gain_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && cmd_code == 2'd2 |=> $stable(gain_word));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));

  a_r7_noise_odd: assert property (@(posedge clk) disable iff (!rst_n)
    done && mode == 2'd2 |-> (^noise_word) == 1'b1);

  a_r7_offset_odd: assert property (@(posedge clk) disable iff (!rst_n)
    done && mode == 2'd3 |-> (^offset_msw) == 1'b1 && (^offset_lsw) == 1'b1);

  a_r2_inoff_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    done && mode == 2'd1 |-> $stable(noise_word) && $stable(offset_msw) && $stable(offset_lsw));

  a_r9_shared_en: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mod_cal_en) == (busy ? NUM_MODS : 0));
endmodule

bind cal_sequencer cal_sequencer_chk #(.WORD_W(WORD_W), .NUM_MODS(NUM_MODS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_code   (cmd_code),
  .filt_strobe(filt_strobe),
  .busy       (busy),
  .done       (done),
  .mode       (mode_q),
  .mod_cal_en (mod_cal_en),
  .noise_word (noise_word),
  .offset_msw (offset_msw),
  .offset_lsw (offset_lsw),
  .gain_word  (gain_word)
);

// File: tb/cal_sequencer_test.sv
`timescale 1ns/1ps
module cal_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cmd_code = 2'd0;
  logic        filt_strobe = 1'b0;
  logic [22:0] noise_data = '0;
  logic [42:0] offset_data = '0;
  logic        busy, done;
  logic [7:0]  mod_cal_en;
  logic [23:0] noise_word, offset_msw, offset_lsw, gain_word;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk = ~clk;

  cal_sequencer uut (
    .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .filt_strobe(filt_strobe),
    .noise_data(noise_data), .offset_data(offset_data), .busy(busy), .done(done),
    .mod_cal_en(mod_cal_en), .noise_word(noise_word), .offset_msw(offset_msw),
    .offset_lsw(offset_lsw), .gain_word(gain_word)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] odd_word(input logic [22:0] d);
    return {d, ~(^d)};
  endfunction

  task automatic start(input logic [1:0] c);
    @(negedge clk) cmd_code = c;
    @(negedge clk) cmd_code = 2'd0;
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) filt_strobe = 1'b1;
      @(negedge clk) filt_strobe = 1'b0;
    end
  endtask

  task automatic t_reset;
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 done", 64'(done), 64'd0);
    check("R1 cal_en", 64'(mod_cal_en), 64'd0);
    check("R1 noise", 64'(noise_word), 64'd0);
    check("R1 msw", 64'(offset_msw), 64'd0);
    check("R1 lsw", 64'(offset_lsw), 64'd0);
    check("R1 gain", 64'(gain_word), 64'h199998);
  endtask

  task automatic t_input_offset;
    noise_data  = 23'h2A5A5A;
    offset_data = 43'h5_1234_5678_9;
    start(2'd1);
    check("R9 enable all", 64'(mod_cal_en), 64'hFF);
    check("R8 busy high", 64'(busy), 64'd1);
    cmd_code = 2'd2;             // R3: ignored while busy
    strobes(20);
    cmd_code = 2'd3;
    strobes(2);
    cmd_code = 2'd0;
    check("R3 lockout busy at 22", 64'(busy), 64'd1);
    check("R2 no done at 22", 64'(done), 64'd0);
    strobes(1);
    check("R2 ends at 23", 64'(busy), 64'd0);
    check("R8 done pulse", 64'(done), 64'd1);
    check("R2 noise untouched", 64'(noise_word), 64'd0);
    check("R2 msw untouched", 64'(offset_msw), 64'd0);
    check("R2 lsw untouched", 64'(offset_lsw), 64'd0);
    @(negedge clk);
    check("R8 done one cycle", 64'(done), 64'd0);
    check("R3 no restart after lockout", 64'(busy), 64'd0);
    check("R9 enable off", 64'(mod_cal_en), 64'd0);
  endtask

  task automatic t_sys_offset(input logic [42:0] v);
    logic [22:0] md, ld;
    md = {{3{v[42]}}, v[41:22]};
    ld = {v[21:0], 1'b0};
    offset_data = v;
    start(2'd3);
    strobes(500);
    repeat (6) @(negedge clk);   // gap with no strobes
    check("R3 busy through gap", 64'(busy), 64'd1);
    strobes(527);
    check("R6 busy at 1027", 64'(busy), 64'd1);
    strobes(1);
    check("R6 ends at 1028", 64'(busy), 64'd0);
    check("R8 done sysoff", 64'(done), 64'd1);
    check("R6 R7 msw", 64'(offset_msw), 64'(odd_word(md)));
    check("R6 R7 lsw", 64'(offset_lsw), 64'(odd_word(ld)));
  endtask

  task automatic t_noise(input logic [22:0] d);
    noise_data = d;
    start(2'd2);
    check("R5 msw cleared", 64'(offset_msw), 64'd0);
    check("R5 lsw cleared", 64'(offset_lsw), 64'd0);
    check("R5 gain kept", 64'(gain_word), 64'h199998);
    strobes(408);
    check("R4 busy at 408", 64'(busy), 64'd1);
    strobes(1);
    check("R4 ends at 409", 64'(busy), 64'd0);
    check("R4 R7 noise word", 64'(noise_word), 64'(odd_word(d)));
    check("R8 done noise", 64'(done), 64'd1);
  endtask

  task automatic t_idle_code;
    @(negedge clk) cmd_code = 2'd0;
    @(negedge clk);
    check("R3 idle code starts nothing", 64'(busy), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_input_offset();
    t_idle_code();
    t_sys_offset(43'h7FF_EDCB_A987);   // negative
    t_noise(23'h1F0F0F);
    t_sys_offset(43'h1AB_CDEF_0123);   // positive
    t_noise(23'h000003);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule